// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block is a clocked reset controller. It merges two reset sources into one output. The first is a digital flag that reports whether the supply is above its sense threshold. The second is a watchdog that firmware must service by pulling the shared chip-select line from high to low. Reset is active from power-up (the asynchronous `rst_n` input). It stays active while the supply is low. It releases only after the supply has been good for a programmable hold period, which stands for about 200 ms expressed in clock cycles.

The watchdog counts clock cycles from the last falling edge of `cs_n`. If none arrives within the selected period, it produces a reset pulse that lasts one hold period. A line that sits steadily low counts as a missed kick, just as one that sits steadily high does. A 2-bit code picks one of three periods or switches the watchdog off.

The timeout code and a write-protect-enable bit live in a small settings register. While the write-protect pin is low and the enable bit is set, writes to that register are dropped. A parameter chooses the reset polarity. A separate output-enable line lets the pad be driven as open drain.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rst_n` is low the reset output is active. After `rst_n` rises with `supply_ok` high, reset stays active for exactly `HOLD_CYC` rising clock edges and then releases.
- R2: When `supply_ok` is low at a rising edge, reset is active after that edge.
- R3: After `supply_ok` returns high, reset releases after `HOLD_CYC` consecutive edges with `supply_ok` high. A dip during the hold restarts the count.
- R4: The timeout code `cfg_sel` selects the watchdog period: 2'b00 gives `WD_LONG_CYC`, 2'b01 gives `WD_MED_CYC` and 2'b10 gives `WD_SHORT_CYC`. With no kick, reset asserts that many edges after it released.
- R5: Code 2'b11 disables the watchdog, so no timeout reset ever occurs.
- R6: A high-to-low transition on `cs_n` (sampled on `clk`) clears the watchdog count. The period is then measured again from that edge.
- R7: Holding `cs_n` steadily low, or steadily high, still produces a timeout.
- R8: A timeout holds reset active for `HOLD_CYC` edges. While reset is active the watchdog count is held at zero, so after release the next timeout comes a full period later.
- R9: A write (`cfg_wr` high, which loads `cfg_sel` and `cfg_wpen`) is ignored while `wp_n` is low and the stored protect-enable bit is 1.
- R10: With `wp_n` high, or with the stored protect-enable bit at 0, a write takes effect.
- R11: `rst_oe` is high exactly when reset is active.
- R12: With `ACTIVE_LOW`=1 the active level of `rst_out` is 0. With `ACTIVE_LOW`=0 it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Supply above sense level |
| cs_n | input | 1 | Chip select, also the watchdog kick (falling edge) |
| wp_n | input | 1 | Write-protect pin, active low |
| cfg_wr | input | 1 | Write strobe for the settings register |
| cfg_sel | input | 2 | Timeout code to write |
| cfg_wpen | input | 1 | Protect-enable bit to write |
| rst_out | output | 1 | Reset output, polarity set by `ACTIVE_LOW` |
| rst_oe | output | 1 | Output enable for an open-drain pad, high when reset is active |

## Verification
The bench measures every period edge by edge. A release that comes one cycle early or late is caught; this is typical of a hold counter that compares against the wrong end value. The bench holds `cs_n` low without a further edge to expose a design that kicks on a level rather than a falling edge; such a design would never time out. It sends a second write under each combination of pin and protect bit and checks the resulting period, which shows a lock that either ignores the pin or blocks every write. It also measures two timeouts back to back, which reveals a counter that keeps running during the reset pulse and fires early.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MED   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  typedef struct packed {
    wd_sel_e sel;
    logic    wpen;
  } supv_cfg_t;
endpackage

// File: rtl/supv_cfg_regs.sv
module supv_cfg_regs
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_sel,
  input  logic       cfg_wpen,
  output supv_cfg_t  cfg
);
  supv_cfg_t cfg_q, cfg_d;
  logic      locked;
  logic      wr_en;

  assign locked = ~wp_n & cfg_q.wpen;
  assign wr_en  = cfg_wr & ~locked;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.sel  = wd_sel_e'(cfg_sel);
      cfg_d.wpen = cfg_wpen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.sel  <= WD_LONG;
      cfg_q.wpen <= 1'b0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

  // R9
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_wr) |=> $stable(cfg_q));

  // R10
  open_write_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && cfg_wr) |=> (cfg_q.sel == $past(cfg_sel) && cfg_q.wpen == $past(cfg_wpen)));
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer #(
  parameter int HOLD_CYC = 1000,
  localparam int HW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wd_timeout,
  output logic rst_active
);
  logic [HW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          trigger;
  logic          last_cyc;

  assign trigger  = ~supply_ok | wd_timeout;
  assign last_cyc = (cnt_q == HW'(HOLD_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (trigger) begin
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      if (last_cyc) begin
        cnt_d = '0;
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign rst_active = act_q;

  // R2
  low_supply_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> rst_active);

  // R3
  release_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active) |-> $past(supply_ok));
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
  import supv_pkg::*;
#(
  parameter int WD_LONG_CYC  = 4000,
  parameter int WD_MED_CYC   = 2000,
  parameter int WD_SHORT_CYC = 500,
  localparam int WW = $clog2(WD_LONG_CYC + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n,
  input  wd_sel_e sel,
  input  logic    hold_rst,
  output logic    timeout
);
  logic [WW-1:0] cnt_q, cnt_d;
  logic [WW-1:0] limit;
  logic          cs_q;
  logic          kick;
  logic          enabled;

  always_comb begin
    case (sel)
      WD_LONG:  limit = WW'(WD_LONG_CYC - 1);
      WD_MED:   limit = WW'(WD_MED_CYC - 1);
      WD_SHORT: limit = WW'(WD_SHORT_CYC - 1);
      default:  limit = WW'(WD_LONG_CYC - 1);
    endcase
  end

  assign enabled = (sel != WD_OFF);
  assign kick    = cs_q & ~cs_n;
  assign timeout = enabled & ~hold_rst & ~kick & (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (hold_rst || !enabled || kick || timeout) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cs_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      cs_q  <= cs_n;
    end
  end

  // R8
  held_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |=> (cnt_q == '0));

  // R6
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !hold_rst) |=> (cnt_q == '0));

  // R5
  off_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !timeout);
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int HOLD_CYC     = 1000,
  parameter int WD_LONG_CYC  = 4000,
  parameter int WD_MED_CYC   = 2000,
  parameter int WD_SHORT_CYC = 500,
  parameter bit ACTIVE_LOW   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       cs_n,
  input  logic       wp_n,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_sel,
  input  logic       cfg_wpen,
  output logic       rst_out,
  output logic       rst_oe
);
  supv_cfg_t cfg;
  logic      wd_timeout;
  logic      rst_active;

  supv_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .cfg_wr   (cfg_wr),
    .cfg_sel  (cfg_sel),
    .cfg_wpen (cfg_wpen),
    .cfg      (cfg)
  );

  supv_watchdog #(
    .WD_LONG_CYC  (WD_LONG_CYC),
    .WD_MED_CYC   (WD_MED_CYC),
    .WD_SHORT_CYC (WD_SHORT_CYC)
  ) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sel      (cfg.sel),
    .hold_rst (rst_active),
    .timeout  (wd_timeout)
  );

  supv_hold_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .supply_ok  (supply_ok),
    .wd_timeout (wd_timeout),
    .rst_active (rst_active)
  );

  generate
    if (ACTIVE_LOW) begin : g_low
      assign rst_out = ~rst_active;
    end else begin : g_high
      assign rst_out = rst_active;
    end
  endgenerate

  assign rst_oe = rst_active;

  // R8
  timeout_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_timeout |=> rst_active);

  // R11
  oe_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_oe == (rst_out == !ACTIVE_LOW));
endmodule

// File: tb/supv_reset_ctrl_tb.sv
module supv_reset_ctrl_tb;
  localparam int HOLD  = 20;
  localparam int LONG  = 60;
  localparam int MED   = 30;
  localparam int SHORT = 12;

  logic clk = 1'b0;
  logic rst_n, supply_ok, cs_n, wp_n, cfg_wr, cfg_wpen;
  logic [1:0] cfg_sel;
  logic rst_out, rst_oe, rst_out_hi, rst_oe_hi;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  supv_reset_ctrl #(.HOLD_CYC(HOLD), .WD_LONG_CYC(LONG), .WD_MED_CYC(MED),
                    .WD_SHORT_CYC(SHORT), .ACTIVE_LOW(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n), .wp_n(wp_n),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wpen(cfg_wpen),
    .rst_out(rst_out), .rst_oe(rst_oe));

  supv_reset_ctrl #(.HOLD_CYC(HOLD), .WD_LONG_CYC(LONG), .WD_MED_CYC(MED),
                    .WD_SHORT_CYC(SHORT), .ACTIVE_LOW(1'b0)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n), .wp_n(wp_n),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wpen(cfg_wpen),
    .rst_out(rst_out_hi), .rst_oe(rst_oe_hi));

  // vector: wp_n, wpen, first code, second code, expected (0 long,1 med,2 short,3 none)
  localparam logic [7:0] VEC [8] = '{
    {1'b1, 1'b0, 2'd0, 2'd0, 2'd0},
    {1'b1, 1'b0, 2'd0, 2'd1, 2'd1},
    {1'b1, 1'b0, 2'd1, 2'd2, 2'd2},
    {1'b0, 1'b1, 2'd2, 2'd0, 2'd2},
    {1'b1, 1'b1, 2'd1, 2'd2, 2'd2},
    {1'b0, 1'b0, 2'd0, 2'd1, 2'd1},
    {1'b0, 1'b1, 2'd1, 2'd3, 2'd1},
    {1'b1, 1'b0, 2'd0, 2'd3, 2'd3}
  };

  function automatic logic act();
    return !rst_out;
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic power_on();
    @(negedge clk);
    rst_n = 1'b0; supply_ok = 1'b1; cs_n = 1'b1; wp_n = 1'b1;
    cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_wpen = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [1:0] s, input logic w);
    cfg_sel = s; cfg_wpen = w; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // negedges until reset reaches the wanted state, -1 past cap
  task automatic wait_state(input logic want, input int cap, output int n);
    n = -1;
    for (int i = 1; i <= cap; i++) begin
      @(negedge clk);
      if (act() == want) begin
        n = i;
        break;
      end
    end
  endtask

  int n;

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // reset state
    power_on();
    check("R1 active during rst_n", int'(act()), 1);
    check("R11 oe during reset", int'(rst_oe), 1);
    check("R12 active-high level", int'(rst_out_hi), 1);
    power_on();
    wait_state(1'b0, 4 * HOLD, n);
    check("R1 power-up hold", n, HOLD);
    check("R11 oe released", int'(rst_oe), 0);
    check("R12 active-high released", int'(rst_out_hi), 0);

    // vector walk over timeout codes and lock
    for (int v = 0; v < 8; v++) begin
      int expv;
      power_on();
      write_cfg(VEC[v][5:4], VEC[v][6]);
      wp_n = VEC[v][7];
      write_cfg(VEC[v][3:2], VEC[v][6]);
      wait_state(1'b0, 4 * HOLD, n);
      case (VEC[v][1:0])
        2'd0: expv = LONG;
        2'd1: expv = MED;
        2'd2: expv = SHORT;
        default: expv = -1;
      endcase
      wait_state(1'b1, 3 * LONG, n);
      check((VEC[v][1:0] == 2'd3) ? "R5 disabled" :
            (VEC[v][7] == 1'b0 && VEC[v][6]) ? "R9 locked period" :
            (v < 3) ? "R4 period" : "R10 unlocked period", n, expv);
    end

    // timeout pulse and counter restart
    power_on();
    write_cfg(2'd2, 1'b0);
    wait_state(1'b0, 4 * HOLD, n);
    wait_state(1'b1, 3 * LONG, n);
    check("R11 oe on timeout", int'(rst_oe), 1);
    wait_state(1'b0, 4 * HOLD, n);
    check("R8 pulse length", n, HOLD);
    wait_state(1'b1, 3 * LONG, n);
    check("R8 restart full period", n, SHORT);

    // kicks keep reset away
    wait_state(1'b0, 4 * HOLD, n);
    for (int k = 0; k < 6; k++) begin
      repeat (SHORT - 4) @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1;
      check("R6 no reset while kicked", int'(act()), 0);
    end
    // steady high after kicks, then steady low after one falling edge
    @(negedge clk);
    cs_n = 1'b0;
    wait_state(1'b1, 3 * LONG, n);
    check("R6 period from kick edge", n, SHORT + 1);
    wait_state(1'b0, 4 * HOLD, n);
    wait_state(1'b1, 3 * LONG, n);
    check("R7 steady low times out", n, SHORT);
    cs_n = 1'b1;
    wait_state(1'b0, 4 * HOLD, n);
    wait_state(1'b1, 3 * LONG, n);
    check("R7 steady high times out", n, SHORT);

    // brownout while running, and dip during hold
    power_on();
    write_cfg(2'd3, 1'b0);
    wait_state(1'b0, 4 * HOLD, n);
    supply_ok = 1'b0;
    @(negedge clk);
    check("R2 brownout asserts", int'(act()), 1);
    repeat (5) @(negedge clk);
    supply_ok = 1'b1;
    repeat (HOLD / 2) @(negedge clk);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    wait_state(1'b0, 4 * HOLD, n);
    check("R3 hold restarts after dip", n, HOLD);
    check("R12 active-high follows", int'(rst_out_hi), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule